// File: doc/BRIEF.md
# Timer Channel: Input Capture, Output Compare and PWM

This block is one channel of a free-running timer. The shared up-counter is outside the block. It supplies its current value on `cnt_i` and a one-cycle `ovf_i` pulse in the cycle that holds the top count, just before it wraps to zero. A two-bit mode select picks one of three modes: input capture, unbuffered compare/PWM, or buffered compare/PWM. A two-bit action select chooses the capture edge or the pin action on a compare match.

In capture mode, a synchronised input pin latches the counter into the channel value on the selected edge. In the compare modes, the channel drives its pin on a match between the counter and the channel value, and can also toggle it on every overflow. Combining the overflow toggle with clear-on-match gives edge-aligned PWM. A separate full-duty control holds the pin high for whole periods. In buffered mode, software writes land in a shadow register, so a duty change never splits a period.

Top module: `tim_channel`

## Requirements
- R1: With `act_sel_i` = 00 the channel does not drive the pin (`pin_oe_o` = 0). After one clock, `pin_o` is high if `mode_sel_i[0]` = 0 and low if `mode_sel_i[0]` = 1.
- R2: With `mode_sel_i` = 00 (capture), `act_sel_i` selects the edge: 01 captures on rising edges, 10 on falling edges, 11 on both. The captured value is `cnt_i` as seen at the third rising clock edge after the pin changes, and it appears on `val_o`.
- R3: In capture mode, a pin edge of the unselected polarity leaves `val_o` and `flag_o` unchanged.
- R4: In a compare mode (`mode_sel_i` ≠ 00) with `act_sel_i` ≠ 00, `cnt_i` == `val_o` acts on the pin at the next clock edge: 01 toggles it, 10 clears it, 11 sets it. `pin_oe_o` is 1.
- R5: In a compare mode with `ovf_toggle_i` = 1, each `ovf_i` toggles the pin. When a match happens in the same cycle, the toggle wins over the match action.
- R6: In capture mode `pin_oe_o` is 0, and neither `ovf_toggle_i` nor `ovf_i` changes `pin_o`.
- R7: With `ovf_toggle_i` = 1 and clear-on-match selected, `full_duty_i` = 1 holds `pin_o` high for every cycle of a period. `full_duty_i` is sampled only at `ovf_i`, so a change takes effect from the following period.
- R8: Clear-on-match with `ovf_toggle_i` = 0 and `full_duty_i` = 0 keeps `pin_o` low for whole periods.
- R9: With `mode_sel_i[1]` = 1 (buffered), `val_wr_i` loads a shadow register, which is copied into the active value only at `ovf_i`. In unbuffered modes, a write updates the active value at the next clock edge.
- R10: A capture, or a compare match in any compare mode (including `act_sel_i` = 00), sets `flag_o`. The flag stays set until `flag_clr_i`. If an event and a clear happen in the same cycle, the event wins.
- R11: Reset clears `flag_o`, `val_o` and the pin state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | W | Shared timer counter value |
| ovf_i | input | 1 | Counter at top value, wraps after this cycle |
| mode_sel_i | input | 2 | 00 capture, 01 compare, 1x buffered compare |
| act_sel_i | input | 2 | Capture edge or match action |
| ovf_toggle_i | input | 1 | Toggle pin on overflow (compare modes) |
| full_duty_i | input | 1 | Force 100 % duty with clear-on-match |
| val_wr_i | input | 1 | Write strobe for channel value |
| val_wdata_i | input | W | Channel value write data |
| flag_clr_i | input | 1 | Clear channel event flag |
| cap_pin_i | input | 1 | Asynchronous capture input |
| pin_o | output | 1 | Channel pin level |
| pin_oe_o | output | 1 | Channel drives the pin |
| flag_o | output | 1 | Sticky event flag |
| val_o | output | W | Active channel value or captured count |

## Verification
The hardest case is an overflow and a compare match in the same cycle. From the ports, this happens only when the channel value equals the counter's top value while the overflow toggle is enabled. The bench starts clear-on-match PWM at a period boundary from a known low pin, with the value set to the top count. It then measures whole periods: the pin is high for a full period only if the toggle beat the clear. The full-duty period latency and the buffered-write boundary are checked in the same way. The control is changed in the middle of a period, and the high time of that period and of the next one is counted.

// File: rtl/tim_ch_pkg.sv
package tim_ch_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;

  typedef enum logic [1:0] {
    MODE_CAPTURE  = 2'b00,
    MODE_COMPARE  = 2'b01,
    MODE_BUFFERED = 2'b10
  } ch_mode_e;

  function automatic ch_mode_e decode_mode(logic [1:0] sel);
    if (sel[1])      return MODE_BUFFERED;
    else if (sel[0]) return MODE_COMPARE;
    else             return MODE_CAPTURE;
  endfunction
endpackage

// File: rtl/tim_ch_edge_sync.sv
module tim_ch_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], in_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tim_ch_value_reg.sv
module tim_ch_value_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buffered_i,
  input  logic         ovf_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] shadow_q, val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (wr_i) shadow_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         val_q <= '0;
    else if (cap_i)      val_q <= cnt_i;
    else if (buffered_i) begin
      if (ovf_i) val_q <= shadow_q;
    end
    else if (wr_i)       val_q <= wr_data_i;
  end

  assign val_o = val_q;

  p_buf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buffered_i && !ovf_i && !cap_i) |=> $stable(val_q));

  p_capture_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (val_q == $past(cnt_i)));
endmodule

// File: rtl/tim_ch_pin_ctrl.sv
module tim_ch_pin_ctrl
  import tim_ch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ch_mode_e mode_i,
  input  logic     preset_i,
  input  logic [1:0] act_sel_i,
  input  logic     tov_i,
  input  logic     max_i,
  input  logic     match_i,
  input  logic     ovf_i,
  output logic     pin_o,
  output logic     pin_oe_o
);
  pin_act_e act;
  logic     pin_q, max_eff_q, drive, force_hi;

  assign act   = pin_act_e'(act_sel_i);
  assign drive = (mode_i != MODE_CAPTURE) && (act != ACT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pin_q <= 1'b0;
    else if (act == ACT_NONE)    pin_q <= preset_i;
    else if (drive) begin
      if (ovf_i && tov_i)        pin_q <= ~pin_q;  // overflow wins
      else if (match_i) begin
        unique case (act)
          ACT_TOGGLE: pin_q <= ~pin_q;
          ACT_CLEAR:  pin_q <= 1'b0;
          ACT_SET:    pin_q <= 1'b1;
          default:    pin_q <= pin_q;
        endcase
      end
    end
  end

  // full-duty request takes effect at period boundaries only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    max_eff_q <= 1'b0;
    else if (ovf_i) max_eff_q <= max_i;
  end

  assign force_hi = drive && max_eff_q && tov_i && (act == ACT_CLEAR);
  assign pin_o    = force_hi | pin_q;
  assign pin_oe_o = drive;

  p_preset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel_i == 2'b00) |=> (pin_q == $past(preset_i)));

  p_clear_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive && match_i && !(ovf_i && tov_i) && act_sel_i == 2'b10) |=> !pin_q);

  p_ovf_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive && ovf_i && tov_i) |=> (pin_q != $past(pin_q)));

  p_capture_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CAPTURE && act_sel_i != 2'b00) |=> $stable(pin_q));

  p_max_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i |=> $stable(max_eff_q));
endmodule

// File: rtl/tim_channel.sv
module tim_channel
  import tim_ch_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         ovf_i,
  input  logic [1:0]   mode_sel_i,
  input  logic [1:0]   act_sel_i,
  input  logic         ovf_toggle_i,
  input  logic         full_duty_i,
  input  logic         val_wr_i,
  input  logic [W-1:0] val_wdata_i,
  input  logic         flag_clr_i,
  input  logic         cap_pin_i,
  output logic         pin_o,
  output logic         pin_oe_o,
  output logic         flag_o,
  output logic [W-1:0] val_o
);
  ch_mode_e     mode;
  logic         rise, fall, cap_evt, match, flag_q;
  logic [W-1:0] val;

  assign mode = decode_mode(mode_sel_i);

  tim_ch_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign cap_evt = (mode == MODE_CAPTURE) &&
                   ((act_sel_i[0] && rise) || (act_sel_i[1] && fall));
  assign match   = (mode != MODE_CAPTURE) && (cnt_i == val);

  tim_ch_value_reg #(.W(W)) u_val (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .buffered_i (mode == MODE_BUFFERED),
    .ovf_i      (ovf_i),
    .wr_i       (val_wr_i),
    .wr_data_i  (val_wdata_i),
    .cap_i      (cap_evt),
    .cnt_i      (cnt_i),
    .val_o      (val)
  );

  tim_ch_pin_ctrl u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .preset_i  (~mode_sel_i[0]),
    .act_sel_i (act_sel_i),
    .tov_i     (ovf_toggle_i),
    .max_i     (full_duty_i),
    .match_i   (match),
    .ovf_i     (ovf_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (cap_evt || match)  flag_q <= 1'b1;
    else if (flag_clr_i)        flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign val_o  = val;

  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  p_flag_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt || match) |=> flag_o);

  p_capture_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i == 2'b00) |-> !pin_oe_o);
endmodule

// File: tb/tim_channel_bench.sv
module tim_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic [W-1:0] modv = 16'd9;
  logic         ovf;
  logic [1:0]   mode_sel = 2'b00, act_sel = 2'b00;
  logic         tov = 1'b0, fdut = 1'b0, wr = 1'b0, fclr = 1'b0, cpin = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         pin, pin_oe, flag;
  logic [W-1:0] val;

  int checks = 0, failures = 0;
  int acc = 0, last_hi = 0, periods = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ovf = (cnt >= modv);

  tim_channel #(.W(W)) u_tim_channel (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .ovf_i(ovf),
    .mode_sel_i(mode_sel), .act_sel_i(act_sel), .ovf_toggle_i(tov),
    .full_duty_i(fdut), .val_wr_i(wr), .val_wdata_i(wdata),
    .flag_clr_i(fclr), .cap_pin_i(cpin), .pin_o(pin), .pin_oe_o(pin_oe),
    .flag_o(flag), .val_o(val)
  );

  // counter model and per-period high-time measurement
  always @(negedge clk) begin : counting
    logic [W-1:0] nxt;
    nxt = ovf ? '0 : cnt + 1'b1;
    if (nxt == '0) begin
      last_hi = acc;
      acc     = int'(pin);
      periods = periods + 1;
    end else begin
      acc = acc + int'(pin);
    end
    cnt <= nxt;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_periods(int n);
    int p0;
    p0 = periods;
    wait (periods >= p0 + n);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // preset the pin low, load value, then start config at a period boundary
  task automatic start_pwm(logic [1:0] m, logic [1:0] a, logic t, int d);
    mode_sel = 2'b01; act_sel = 2'b00; tov = 1'b0;
    wr = 1'b1; wdata = W'(d);
    tick(1);
    wr = 1'b0;
    wait_periods(1);
    mode_sel = m; act_sel = a; tov = t;
  endtask

  task automatic capture_edge(logic v, output int exp);
    int c;
    tick(1);
    c    = int'(cnt);
    cpin = v;
    exp  = (c + 3) % (int'(modv) + 1);
    tick(5);
  endtask

  task automatic clear_flag();
    fclr = 1'b1; tick(1); fclr = 1'b0; tick(1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : main
    int exp, v0;
    tick(3);
    // R11 reset state
    check("R11 flag", int'(flag), 0);
    check("R11 val", int'(val), 0);
    check("R11 oe", int'(pin_oe), 0);
    rst_n = 1'b1;
    tick(2);

    // R1 port control presets
    mode_sel = 2'b00; act_sel = 2'b00; tick(2);
    check("R1 preset high", int'(pin), 1);
    check("R1 oe", int'(pin_oe), 0);
    mode_sel = 2'b01; tick(2);
    check("R1 preset low", int'(pin), 0);

    // R4 R5 sweep over all match actions and values
    for (int a = 1; a <= 3; a++) begin
      for (int d = 0; d < 9; d++) begin
        start_pwm(2'b01, 2'(a), 1'b1, d);
        wait_periods(3);
        check(a == 2 ? "R4 R5 clear duty" : "R4 R5 toggle/set duty",
              last_hi, (a == 2) ? d + 1 : 9 - d);
      end
    end
    check("R4 oe", int'(pin_oe), 1);

    // R9 buffered sweep with clear-on-match
    for (int d = 0; d < 9; d++) begin
      start_pwm(2'b10, 2'b10, 1'b1, d);
      wait_periods(3);
      check("R9 buffered duty", last_hi, d + 1);
    end

    // R5 overflow wins over coincident clear
    start_pwm(2'b01, 2'b10, 1'b1, 9);
    wait_periods(2);
    check("R5 precedence", last_hi, 10);

    // R8 zero duty
    start_pwm(2'b01, 2'b10, 1'b0, 3);
    wait_periods(3);
    check("R8 zero duty", last_hi, 0);

    // R7 full duty with one-period latency, on and off
    start_pwm(2'b01, 2'b10, 1'b1, 3);
    wait_periods(3);
    check("R7 base", last_hi, 4);
    tick(4); fdut = 1'b1;
    wait_periods(1);
    check("R7 same period", last_hi, 4);
    wait_periods(1);
    check("R7 forced", last_hi, 10);
    tick(4); fdut = 1'b0;
    wait_periods(1);
    check("R7 still forced", last_hi, 10);
    wait_periods(1);
    check("R7 released", last_hi, 4);

    // R9 buffered write lands at next period
    start_pwm(2'b10, 2'b10, 1'b1, 2);
    wait_periods(3);
    tick(1);
    wr = 1'b1; wdata = 16'd6; tick(1); wr = 1'b0;
    wait_periods(1);
    check("R9 buffered old period", last_hi, 3);
    wait_periods(1);
    check("R9 buffered new period", last_hi, 7);
    // unbuffered write acts immediately
    start_pwm(2'b01, 2'b10, 1'b1, 2);
    wait_periods(3);
    tick(1);
    wr = 1'b1; wdata = 16'd6; tick(1); wr = 1'b0;
    wait_periods(1);
    check("R9 unbuffered immediate", last_hi, 7);

    // R10 flag from software-only compare
    mode_sel = 2'b01; act_sel = 2'b00;
    wr = 1'b1; wdata = 16'd5; tick(1); wr = 1'b0;
    wait_periods(1);
    clear_flag();
    tick(12);
    check("R10 soft compare flag", int'(flag), 1);
    check("R1 soft compare oe", int'(pin_oe), 0);

    // R6 capture mode ignores overflow toggle
    mode_sel = 2'b00; act_sel = 2'b01; tov = 1'b1; fdut = 1'b1;
    tick(2);
    v0 = int'(pin);
    tick(25);
    check("R6 pin held", int'(pin), v0);
    check("R6 oe", int'(pin_oe), 0);
    fdut = 1'b0; tov = 1'b0;

    // R2 R3 captures, wide modulo
    modv = 16'd999;
    tick(2);
    clear_flag();
    capture_edge(1'b1, exp);
    check("R2 rising val", int'(val), exp);
    check("R10 capture flag", int'(flag), 1);
    v0 = int'(val);
    clear_flag();
    check("R10 flag cleared", int'(flag), 0);
    capture_edge(1'b0, exp);
    check("R3 falling ignored flag", int'(flag), 0);
    check("R3 falling ignored val", int'(val), v0);

    act_sel = 2'b10; tick(1);
    capture_edge(1'b1, exp);
    check("R3 rising ignored flag", int'(flag), 0);
    check("R3 rising ignored val", int'(val), v0);
    capture_edge(1'b0, exp);
    check("R2 falling val", int'(val), exp);
    check("R2 falling flag", int'(flag), 1);

    act_sel = 2'b11; tick(1);
    clear_flag();
    capture_edge(1'b1, exp);
    check("R2 both rise val", int'(val), exp);
    clear_flag();
    capture_edge(1'b0, exp);
    check("R2 both fall val", int'(val), exp);
    check("R2 both flag", int'(flag), 1);

    finish_run();
  end
endmodule